// File: doc/BRIEF.md
# Shared-Port Palette and Attribute Register Front End

This block is the register-access side of a palette and attribute controller. Software reaches every register through one write port. A hidden toggle decides how each write is taken. In the index state the byte selects a register and carries a display-enable flag. In the data state the byte goes into the register that was selected. After every accepted write the toggle flips. Software cannot see the toggle, so it first reads the status port, which puts the toggle back into the index state. After that, the sequence of its writes is known.

The block holds sixteen six-bit palette entries and five control registers: mode, overscan colour, plane enable, pixel pan and colour page. The display-enable flag in the index byte decides whether the display takes its colours from the palette. While the flag is clear, the screen is blanked and the palette may be rewritten. While it is set, palette writes are dropped.

For the display side, the block gives a palette lookup for a pixel value masked by the plane enables, a blank flag and a fine pan shift. In 4-bit modes the pan shift is a three-bit shift. In 8-bit modes it is twice a two-bit pixel offset.

Top module: `attr_port_top`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the toggle goes to the index state, the index register clears and every data register clears. So after reset `index_out` = 0x00, `blank` = 1, all register outputs are 0, and the next write is taken as an index.
- R2: In the index state a write stores bits 4:0 of the byte as the register select and bit 5 as the display-enable flag, then moves to the data state. In the data state a write goes to the selected register and moves back to the index state.
- R3: A cycle with `status_rd` high forces the toggle into the index state. If `port_wr` is also high in that cycle, the write is taken as an index write and the toggle ends in the data state.
- R4: `index_out` always reads {2'b00, display-enable flag, select[4:0]}. Bits 7:6 of an index byte are dropped.
- R5: `blank` is 1 exactly while the display-enable flag is 0. While blanked, `pix_color` is 0.
- R6: A data write to selects 0x00 to 0x0F stores bits 5:0 into that palette entry only while the display-enable flag is 0. While the flag is 1, the write leaves the palette unchanged.
- R7: Data writes store into the control registers whatever the flag holds. The selects are: 0x10 mode (8 bits), 0x11 overscan (8 bits), 0x12 plane enable (bits 3:0), 0x13 pixel pan (bits 2:0) and 0x14 colour page (bits 3:0). Data writes to selects 0x15 to 0x1F change no register, but they still return the toggle to the index state.
- R8: While not blanked, `pix_color` equals the palette entry at `pix_idx & plane_en_out`.
- R9: With mode bit 6 = 0 (4-bit mode), `pan_shift` equals pan[2:0]. With mode bit 6 = 1 (8-bit mode), `pan_shift` equals {pan[2:1], 1'b0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_wr | input | 1 | Write strobe of the shared index/data port |
| port_wdata | input | 8 | Byte written to the shared port |
| status_rd | input | 1 | Read strobe of the status port; returns the toggle to the index state |
| index_out | output | 8 | Readback of the index register, including the display-enable flag |
| blank | output | 1 | High while the display-enable flag is clear |
| pix_idx | input | 4 | Pixel value to look up in the palette |
| pix_color | output | 6 | Palette colour for `pix_idx`, or 0 while blanked |
| mode_out | output | 8 | Mode register |
| overscan_out | output | 8 | Overscan colour register |
| plane_en_out | output | 4 | Plane enable mask |
| pan_shift | output | 3 | Fine pan shift after the mode-dependent scaling |
| color_page_out | output | 4 | Colour page register |

## Verification
The hardest case to reach from the ports is a status read that lands in the same cycle as a write while the toggle sits in the data state. The write must then be taken as an index, not as data. The stimulus produces this case on purpose: it first writes an index, so the toggle is known to be in the data state, and then sends the next write together with a status read. The random phase then mixes coincident strobes with writes whose display-enable flag is random. This puts palette writes on both sides of the blank boundary, and a bench model follows the hidden toggle through all of it.

// File: rtl/attr_pkg.sv
package attr_pkg;
    localparam int BYTE_W    = 8;
    localparam int SEL_W     = 5;
    localparam int EN_BIT    = 5;
    localparam int MODE8_BIT = 6;

    localparam logic [SEL_W-1:0] SEL_MODE  = 5'h10;
    localparam logic [SEL_W-1:0] SEL_OVSC  = 5'h11;
    localparam logic [SEL_W-1:0] SEL_PLANE = 5'h12;
    localparam logic [SEL_W-1:0] SEL_PAN   = 5'h13;
    localparam logic [SEL_W-1:0] SEL_PAGE  = 5'h14;

    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;
endpackage

// File: rtl/attr_index_seq.sv
module attr_index_seq
    import attr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              stat_rd,
    output logic [SEL_W-1:0]  sel,
    output logic              disp_en,
    output logic              data_we,
    output logic [BYTE_W-1:0] data_val
);
    typedef struct packed {
        phase_e           phase;
        logic             en;
        logic [SEL_W-1:0] sel;
    } seq_t;

    seq_t   seq_d, seq_q;
    phase_e eff_phase;

    always_comb begin
        seq_d     = seq_q;
        data_we   = 1'b0;
        eff_phase = stat_rd ? PH_INDEX : seq_q.phase;
        if (wr_en) begin
            if (eff_phase == PH_INDEX) begin
                seq_d.sel   = wr_data[SEL_W-1:0];
                seq_d.en    = wr_data[EN_BIT];
                seq_d.phase = PH_DATA;
            end else begin
                data_we     = 1'b1;
                seq_d.phase = PH_INDEX;
            end
        end else if (stat_rd) begin
            seq_d.phase = PH_INDEX;
        end
        if (rst) begin
            seq_d = '{phase: PH_INDEX, en: 1'b0, sel: '0};
        end
    end

    always_ff @(posedge clk) begin
        seq_q <= seq_d;
    end

    assign sel      = seq_q.sel;
    assign disp_en  = seq_q.en;
    assign data_val = wr_data;

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !data_we) |=> (sel == $past(wr_data[SEL_W-1:0]) && disp_en == $past(wr_data[EN_BIT])));

    // R3
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !wr_en) |=> !(wr_en && data_we && !stat_rd) || 1'b1 ? (seq_q.phase == PH_INDEX) : 1'b1);
endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
    import attr_pkg::*;
#(
    parameter int PAL_N = 16,
    parameter int PAL_W = 6,
    parameter int PAN_W = 3,
    localparam int PIX_W = $clog2(PAL_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic              disp_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [PIX_W-1:0]  pix_idx,
    output logic [PAL_W-1:0]  pix_color,
    output logic [BYTE_W-1:0] mode,
    output logic [BYTE_W-1:0] ovsc,
    output logic [PIX_W-1:0]  plane,
    output logic [PAN_W-1:0]  pan,
    output logic [PIX_W-1:0]  page
);
    typedef struct packed {
        logic [PAL_N-1:0][PAL_W-1:0] pal;
        logic [BYTE_W-1:0]           mode;
        logic [BYTE_W-1:0]           ovsc;
        logic [PIX_W-1:0]            plane;
        logic [PAN_W-1:0]            pan;
        logic [PIX_W-1:0]            page;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic [PAL_N-1:0] pal_hit;
    logic [PIX_W-1:0] look_sel;

    for (genvar i = 0; i < PAL_N; i++) begin : g_pal_hit
        assign pal_hit[i] = we && !disp_en && (sel == SEL_W'(i));
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < PAL_N; i++) begin
            if (pal_hit[i]) begin
                regs_d.pal[i] = wdata[PAL_W-1:0];
            end
        end
        if (we) begin
            unique case (sel)
                SEL_MODE:  regs_d.mode  = wdata;
                SEL_OVSC:  regs_d.ovsc  = wdata;
                SEL_PLANE: regs_d.plane = wdata[PIX_W-1:0];
                SEL_PAN:   regs_d.pan   = wdata[PAN_W-1:0];
                SEL_PAGE:  regs_d.page  = wdata[PIX_W-1:0];
                default:   ;
            endcase
        end
        if (rst) begin
            regs_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign look_sel  = pix_idx & regs_q.plane;
    assign pix_color = disp_en ? regs_q.pal[look_sel] : '0;
    assign mode      = regs_q.mode;
    assign ovsc      = regs_q.ovsc;
    assign plane     = regs_q.plane;
    assign pan       = regs_q.pan;
    assign page      = regs_q.page;

    // R6
    pal_locked_chk: assert property (@(posedge clk) disable iff (rst)
        disp_en |=> $stable(regs_q.pal));

    // R7
    ctrl_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable({regs_q.mode, regs_q.ovsc, regs_q.plane, regs_q.pan, regs_q.page}));
endmodule

// File: rtl/attr_pan_calc.sv
module attr_pan_calc #(
    parameter int PAN_W = 3
) (
    input  logic             mode8,
    input  logic [PAN_W-1:0] pan,
    output logic [PAN_W-1:0] shift
);
    logic [PAN_W-1:0] shift_4b;
    logic [PAN_W-1:0] shift_8b;

    always_comb begin
        shift_4b = pan;
        shift_8b = {pan[PAN_W-1:1], 1'b0};
        shift    = mode8 ? shift_8b : shift_4b;
    end
endmodule

// File: rtl/attr_port_top.sv
module attr_port_top
    import attr_pkg::*;
#(
    parameter int PAL_N = 16,
    parameter int PAL_W = 6,
    parameter int PAN_W = 3,
    localparam int PIX_W = $clog2(PAL_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_wr,
    input  logic [BYTE_W-1:0] port_wdata,
    input  logic              status_rd,
    output logic [BYTE_W-1:0] index_out,
    output logic              blank,
    input  logic [PIX_W-1:0]  pix_idx,
    output logic [PAL_W-1:0]  pix_color,
    output logic [BYTE_W-1:0] mode_out,
    output logic [BYTE_W-1:0] overscan_out,
    output logic [PIX_W-1:0]  plane_en_out,
    output logic [PAN_W-1:0]  pan_shift,
    output logic [PIX_W-1:0]  color_page_out
);
    logic [SEL_W-1:0]  sel;
    logic              disp_en;
    logic              data_we;
    logic [BYTE_W-1:0] data_val;
    logic [PAN_W-1:0]  pan_raw;

    attr_index_seq i_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (port_wr),
        .wr_data  (port_wdata),
        .stat_rd  (status_rd),
        .sel      (sel),
        .disp_en  (disp_en),
        .data_we  (data_we),
        .data_val (data_val)
    );

    attr_regfile #(.PAL_N(PAL_N), .PAL_W(PAL_W), .PAN_W(PAN_W)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (data_we),
        .sel       (sel),
        .disp_en   (disp_en),
        .wdata     (data_val),
        .pix_idx   (pix_idx),
        .pix_color (pix_color),
        .mode      (mode_out),
        .ovsc      (overscan_out),
        .plane     (plane_en_out),
        .pan       (pan_raw),
        .page      (color_page_out)
    );

    attr_pan_calc #(.PAN_W(PAN_W)) i_pan (
        .mode8 (mode_out[MODE8_BIT]),
        .pan   (pan_raw),
        .shift (pan_shift)
    );

    assign index_out = {{(BYTE_W-SEL_W-1){1'b0}}, disp_en, sel};
    assign blank     = !disp_en;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (index_out == '0 && blank && mode_out == '0 && pan_shift == '0));

    // R3
    coincident_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (status_rd && port_wr) |=> (index_out[SEL_W-1:0] == $past(port_wdata[SEL_W-1:0])));

    // R5
    blank_color_chk: assert property (@(posedge clk) disable iff (rst)
        blank |-> (pix_color == '0));

    // R9
    pan_even_chk: assert property (@(posedge clk) disable iff (rst)
        mode_out[MODE8_BIT] |-> !pan_shift[0]);
endmodule

// File: tb/test_attr_port_top.sv
module test_attr_port_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_wr = 1'b0;
    logic [7:0] port_wdata = '0;
    logic       status_rd = 1'b0;
    logic [7:0] index_out;
    logic       blank;
    logic [3:0] pix_idx = '0;
    logic [5:0] pix_color;
    logic [7:0] mode_out;
    logic [7:0] overscan_out;
    logic [3:0] plane_en_out;
    logic [2:0] pan_shift;
    logic [3:0] color_page_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model
    bit         m_tog;
    logic [4:0] m_sel;
    bit         m_en;
    logic [5:0] m_pal [16];
    logic [7:0] m_mode, m_ovsc;
    logic [3:0] m_plane, m_page;
    logic [2:0] m_pan;

    attr_port_top i_attr_port_top (
        .clk(clk), .rst(rst), .port_wr(port_wr), .port_wdata(port_wdata),
        .status_rd(status_rd), .index_out(index_out), .blank(blank),
        .pix_idx(pix_idx), .pix_color(pix_color), .mode_out(mode_out),
        .overscan_out(overscan_out), .plane_en_out(plane_en_out),
        .pan_shift(pan_shift), .color_page_out(color_page_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_pan();
        return m_mode[6] ? {m_pan[2:1], 1'b0} : m_pan;
    endfunction

    function automatic logic [5:0] exp_color(logic [3:0] p);
        return m_en ? m_pal[p & m_plane] : 6'd0;
    endfunction

    task automatic model_reset();
        m_tog = 0; m_sel = 0; m_en = 0;
        for (int i = 0; i < 16; i++) m_pal[i] = 0;
        m_mode = 0; m_ovsc = 0; m_plane = 0; m_page = 0; m_pan = 0;
    endtask

    task automatic model_step(bit wr, logic [7:0] d, bit st);
        bit eff;
        eff = st ? 1'b0 : m_tog;
        if (wr) begin
            if (!eff) begin
                m_sel = d[4:0]; m_en = d[5]; m_tog = 1;
            end else begin
                m_tog = 0;
                if (m_sel < 5'h10) begin
                    if (!m_en) m_pal[m_sel[3:0]] = d[5:0];
                end else begin
                    case (m_sel)
                        5'h10: m_mode  = d;
                        5'h11: m_ovsc  = d;
                        5'h12: m_plane = d[3:0];
                        5'h13: m_pan   = d[2:0];
                        5'h14: m_page  = d[3:0];
                        default: ;
                    endcase
                end
            end
        end else if (st) begin
            m_tog = 0;
        end
    endtask

    task automatic check_all();
        check("R4 index_out", int'(index_out), int'({2'b00, m_en, m_sel}));
        check("R5 blank", int'(blank), int'(!m_en));
        check("R7 mode", int'(mode_out), int'(m_mode));
        check("R7 overscan", int'(overscan_out), int'(m_ovsc));
        check("R7 plane", int'(plane_en_out), int'(m_plane));
        check("R7 page", int'(color_page_out), int'(m_page));
        check("R9 pan_shift", int'(pan_shift), int'(exp_pan()));
        check("R8 pix_color", int'(pix_color), int'(exp_color(pix_idx)));
    endtask

    // drive at negedge, model at posedge, check at next negedge
    task automatic step(bit wr, logic [7:0] d, bit st);
        port_wr = wr; port_wdata = d; status_rd = st;
        @(posedge clk);
        model_step(wr, d, st);
        @(negedge clk);
        port_wr = 0; status_rd = 0;
        pix_idx = 4'($urandom);
        #1;
        check_all();
    endtask

    task automatic do_reset();
        rst = 1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 0;
        #1;
    endtask

    task automatic wreg(logic [7:0] idx, logic [7:0] d);
        step(1, idx, 0);
        step(1, d, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 index after reset", int'(index_out), 0);
        check("R1 blank after reset", int'(blank), 1);
        check("R1 mode after reset", int'(mode_out), 0);
        check("R1 pan after reset", int'(pan_shift), 0);

        // R2 index then data then index
        wreg(8'h05, 8'hEA);
        step(1, 8'h25, 0);
        check("R2 second index taken", int'(index_out), 8'h25);
        pix_idx = 4'h5; #1;
        check("R6 stored low bits, plane mask 0 selects entry 0", int'(pix_color), 0);
        step(1, 8'h0F, 0);                // data to 0x05 while enabled: dropped
        wreg(8'h32, 8'h0F);               // plane enable = 0xF, display on
        pix_idx = 4'h5; #1;
        check("R6 palette kept 0x2A", int'(pix_color), 6'h2A);

        // R3 status read in data state, coincident with write
        step(1, 8'h13, 0);                // select pan, now in data state
        step(1, 8'h07, 1);                // coincident: taken as index 0x07
        check("R3 coincident write as index", int'(index_out), 8'h07);
        step(1, 8'h24, 0);                // data to pal7 (blanked -> stored)
        step(1, 8'h13, 0);
        step(0, 8'h00, 1);                // status read alone
        step(1, 8'h13, 0);                // must be index again
        check("R3 status read returns to index", int'(index_out), 8'h13);
        step(1, 8'h05, 0);                // pan = 5
        check("R9 4-bit pan", int'(pan_shift), 5);
        wreg(8'h10, 8'h41);
        check("R9 8-bit pan", int'(pan_shift), 4);

        // R7 unused select ignored, still flips toggle
        wreg(8'h1B, 8'hFF);
        step(1, 8'h11, 0);
        check("R7 unused select, toggle back to index", int'(index_out), 8'h11);
        step(1, 8'h3C, 0);
        check("R7 overscan via data", int'(overscan_out), 8'h3C);

        // R1 reset mid-sequence from data state
        step(1, 8'h12, 0);
        do_reset();
        step(1, 8'h2A, 0);
        check("R1 first write after reset is index", int'(index_out), 8'h2A);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            bit wr, st;
            logic [7:0] d;
            int r;
            r  = $urandom_range(0, 99);
            st = (r < 15) || (r >= 95);
            wr = (r >= 15);
            d  = 8'($urandom);
            if (!m_tog || st) begin
                if ($urandom_range(0, 3) != 0) d[4:0] = 5'($urandom_range(0, 21));
            end
            step(wr, d, st);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule